// File: doc/BRIEF.md
# T1 Gapped Channel Clock Generator

This block sits between a recovered T1 bit stream and a system-side consumer, such as a serial HDLC engine. It cuts the line bit rate down to a chosen set of 64 kbit/s channels. The line bit clock enters as a clock enable. The block follows each 193-position frame: one overhead position, then 24 channel slots of eight bits each. It passes an output clock enable only on bits that belong to channels picked by a 24-bit mask. The overhead position is never clocked out, so when the clock is gapped the consumer sees frame alignment as a hole in the clock, and it needs no frame pulse.

A mode input turns gapping off. In that full-rate mode every payload bit is clocked, the mask does nothing, and a one-cycle frame pulse marks the overhead position instead. A free-running divide-by-193 of the line clock enable gives a frame-rate (8 kHz) reference pulse in both modes. An alignment strobe, given together with a line clock enable, forces that bit to be the overhead position. This lets an upstream framer re-phase the counter.

Top module: `t1_gap_clk_gen`

## Requirements
- R1: The position counter steps once per asserted `bit_en_i` through positions 0 to 192. Position 0 is the overhead bit. After position 192 it returns to 0 with no strobe needed.
- R2: The overhead position (position 0) never raises `gclk_o`, in either mode and for any mask value.
- R3: With `gap_en_i`=1, a payload bit at position p (1..192) raises `gclk_o` exactly when mask bit (p-1)/8 is set. Mask bit 0 is the first channel after the overhead bit. A frame therefore carries 8 times the number of set mask bits in clock pulses, which is anywhere from 0 to 192.
- R4: The mask is captured on the overhead position. A change to `chan_mask_i` later in a frame does not alter that frame's gapping, and it takes effect from the next overhead position.
- R5: With `gap_en_i`=1, `frame_pulse_o` stays low.
- R6: With `gap_en_i`=0, `gclk_o` is raised on all 192 payload positions whatever the mask holds. `frame_pulse_o` is raised only for the overhead position.
- R7: `data_o` carries the `data_i` value of a position that raises `gclk_o`, and it is 0 on every other cycle.
- R8: `sync_i` high together with `bit_en_i` makes that bit position 0. Counting then carries on from position 1.
- R9: `ref8k_o` pulses once every 193 asserted `bit_en_i`, starting with the first one after reset. `sync_i` does not affect it.
- R10: All outputs are registered. They respond in the cycle after the `bit_en_i` cycle they belong to and last one cycle. A cycle without `bit_en_i` produces all-zero outputs.
- R11: While `rst_ni` is low all outputs are 0. After reset the first `bit_en_i` is taken as position 0, and the captured mask is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Line bit clock enable, one per T1 bit |
| sync_i | input | 1 | Alignment strobe: the current bit is the overhead position |
| gap_en_i | input | 1 | 1 = gapped per-channel clock, 0 = full-rate with frame pulse |
| chan_mask_i | input | 24 | Channel select, bit i = channel i |
| data_i | input | 1 | Line data bit for the current position |
| gclk_o | output | 1 | Gapped clock enable |
| data_o | output | 1 | Data bit on clocked positions, 0 elsewhere |
| frame_pulse_o | output | 1 | Overhead-position marker in full-rate mode |
| ref8k_o | output | 1 | One pulse per 193 line bits |

## Verification
Every output comes one register stage after the edge where `bit_en_i` is sampled. The bench drives each bit on a falling edge and reads the outputs on the very next falling edge, so each value is checked against the position it was driven for. The mask is captured at position 0 and used from position 1. Expected gapping is therefore worked out from the mask value applied at the overhead bit, even when the input changes later in the frame. The reference pulse is predicted from a count of enabled bits since reset that ignores the strobe.

// File: rtl/t1gc_pkg.sv
package t1gc_pkg;

  typedef enum logic {
    GAP_OFF = 1'b0,
    GAP_ON  = 1'b1
  } gap_mode_e;

  // one overhead bit plus all channel slots
  function automatic int unsigned frame_len(int unsigned n_chan, int unsigned chan_bits);
    return n_chan * chan_bits + 1;
  endfunction

endpackage

// File: rtl/t1gc_pos_counter.sv
module t1gc_pos_counter #(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             sync_i,
  output logic [POS_W-1:0] pos_o,
  output logic             fbit_o
);

  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] cnt_q;

  // strobe overrides the running count for this bit
  assign pos_o  = sync_i ? '0 : cnt_q;
  assign fbit_o = (pos_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (bit_en_i) begin
      cnt_q <= (pos_o == LAST) ? '0 : pos_o + POS_W'(1);
    end
  end

endmodule

// File: rtl/t1gc_slot_gate.sv
module t1gc_slot_gate
  import t1gc_pkg::*;
#(
  parameter int unsigned N_CHAN    = 24,
  parameter int unsigned CHAN_BITS = 8,
  parameter int unsigned POS_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              fbit_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              gap_en_i,
  input  logic [N_CHAN-1:0] mask_i,
  output logic              slot_on_o
);

  localparam int unsigned CH_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1;

  gap_mode_e         mode;
  logic [N_CHAN-1:0] mask_q;
  logic [POS_W-1:0]  off;
  logic [POS_W-1:0]  idx_full;
  logic              chan_sel;

  assign mode = gap_mode_e'(gap_en_i);
  assign off  = pos_i - POS_W'(1);

  generate
    if ((CHAN_BITS & (CHAN_BITS - 1)) == 0) begin : g_shift_idx
      assign idx_full = off >> $clog2(CHAN_BITS);
    end else begin : g_div_idx
      assign idx_full = off / POS_W'(CHAN_BITS);
    end
  endgenerate

  assign chan_sel = (idx_full < POS_W'(N_CHAN)) ? mask_q[idx_full[CH_W-1:0]] : 1'b0;

  // mask is frozen for the whole frame at the overhead bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (bit_en_i && fbit_i) begin
      mask_q <= mask_i;
    end
  end

  always_comb begin
    slot_on_o = 1'b0;
    if (!fbit_i) begin
      unique case (mode)
        GAP_ON:  slot_on_o = chan_sel;
        GAP_OFF: slot_on_o = 1'b1;
        default: slot_on_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/t1gc_ref_div.sv
module t1gc_ref_div #(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned DIV_W      = $clog2(FRAME_BITS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  output logic pulse_o
);

  localparam logic [DIV_W-1:0] LAST = DIV_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] div_q;

  assign pulse_o = bit_en_i && (div_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (bit_en_i) begin
      div_q <= (div_q == LAST) ? '0 : div_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/t1_gap_clk_gen.sv
module t1_gap_clk_gen
  import t1gc_pkg::*;
#(
  parameter int unsigned N_CHAN    = 24,
  parameter int unsigned CHAN_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              sync_i,
  input  logic              gap_en_i,
  input  logic [N_CHAN-1:0] chan_mask_i,
  input  logic              data_i,
  output logic              gclk_o,
  output logic              data_o,
  output logic              frame_pulse_o,
  output logic              ref8k_o
);

  localparam int unsigned FRAME_BITS = frame_len(N_CHAN, CHAN_BITS);
  localparam int unsigned POS_W      = $clog2(FRAME_BITS);

  logic [POS_W-1:0] pos;
  logic             fbit;
  logic             slot_on;
  logic             ref_pulse;

  logic gclk_q, data_q, fp_q, ref_q;

  t1gc_pos_counter #(
    .FRAME_BITS (FRAME_BITS),
    .POS_W      (POS_W)
  ) i_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .sync_i   (sync_i),
    .pos_o    (pos),
    .fbit_o   (fbit)
  );

  t1gc_slot_gate #(
    .N_CHAN    (N_CHAN),
    .CHAN_BITS (CHAN_BITS),
    .POS_W     (POS_W)
  ) i_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .fbit_i    (fbit),
    .pos_i     (pos),
    .gap_en_i  (gap_en_i),
    .mask_i    (chan_mask_i),
    .slot_on_o (slot_on)
  );

  t1gc_ref_div #(
    .FRAME_BITS (FRAME_BITS),
    .DIV_W      (POS_W)
  ) i_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .pulse_o  (ref_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gclk_q <= 1'b0;
      data_q <= 1'b0;
      fp_q   <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      gclk_q <= bit_en_i && slot_on;
      data_q <= bit_en_i && slot_on && data_i;
      fp_q   <= bit_en_i && fbit && !gap_en_i;
      ref_q  <= ref_pulse;
    end
  end

  assign gclk_o        = gclk_q;
  assign data_o        = data_q;
  assign frame_pulse_o = fp_q;
  assign ref8k_o       = ref_q;

endmodule

// File: rtl/t1gc_checker.sv
module t1gc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic gap_en_i,
  input logic gclk_o,
  input logic data_o,
  input logic frame_pulse_o,
  input logic ref8k_o
);

  a_r10_gclk_after_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gclk_o |-> $past(bit_en_i));

  a_r10_fp_after_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |-> $past(bit_en_i));

  a_r2_no_fbit_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |-> !gclk_o);

  a_r5_no_fp_gapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |-> !$past(gap_en_i));

  a_r7_data_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gclk_o |-> !data_o);

  a_r9_ref_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref8k_o |=> !ref8k_o);

endmodule

bind t1_gap_clk_gen t1gc_checker i_t1gc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bit_en_i      (bit_en_i),
  .gap_en_i      (gap_en_i),
  .gclk_o        (gclk_o),
  .data_o        (data_o),
  .frame_pulse_o (frame_pulse_o),
  .ref8k_o       (ref8k_o)
);

// File: tb/test_t1_gap_clk_gen.sv
module test_t1_gap_clk_gen;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        gap_en_i = 1'b0;
  logic [23:0] chan_mask_i = '0;
  logic        data_i = 1'b0;
  logic        gclk_o, data_o, frame_pulse_o, ref8k_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_en = 0;
  int ref_err = 0;

  always #5 clk = ~clk;

  t1_gap_clk_gen i_t1_gap_clk_gen (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .bit_en_i      (bit_en_i),
    .sync_i        (sync_i),
    .gap_en_i      (gap_en_i),
    .chan_mask_i   (chan_mask_i),
    .data_i        (data_i),
    .gclk_o        (gclk_o),
    .data_o        (data_o),
    .frame_pulse_o (frame_pulse_o),
    .ref8k_o       (ref8k_o)
  );

  // {gap_en, mask}
  localparam logic [24:0] VEC [7] = '{
    {1'b1, 24'hFFFFFF},
    {1'b1, 24'h000000},
    {1'b1, 24'h000001},
    {1'b1, 24'h800000},
    {1'b1, 24'hA5A5A5},
    {1'b0, 24'h000000},
    {1'b0, 24'h123456}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic dpat(input int p);
    return logic'(((p >> 0) ^ (p >> 3) ^ (p >> 5)) & 1);
  endfunction

  // one enabled bit: drive at falling edge, read outputs at the next falling edge
  task automatic bit_step(input logic sy, input logic gp, input logic [23:0] m, input logic d);
    bit_en_i = 1'b1; sync_i = sy; gap_en_i = gp; chan_mask_i = m; data_i = d;
    @(posedge clk);
    @(negedge clk);
    if (ref8k_o !== ((n_en % 193) == 0)) ref_err++;
    n_en++;
  endtask

  task automatic run_frame(input logic gp, input logic [23:0] m, input logic [23:0] m_late,
                           input bit do_sync, input string req);
    int pos_bad = 0;
    int pulses = 0;
    int exp_pulses;
    for (int p = 0; p < 193; p++) begin
      logic eg, efp, ed;
      bit_step((p == 0) && do_sync, gp, (p == 0) ? m : m_late, dpat(p));
      eg  = (p != 0) && (!gp || m[(p - 1) / 8]);
      efp = (p == 0) && !gp;
      ed  = eg && dpat(p);
      if (gclk_o !== eg || frame_pulse_o !== efp || data_o !== ed) pos_bad++;
      if (gclk_o === 1'b1) pulses++;
    end
    exp_pulses = gp ? 8 * $countones(m) : 192;
    chk(pos_bad == 0, {req, " per-position outputs (R2 R7)"}, pos_bad, 0);
    chk(pulses == exp_pulses, {req, " pulse count"}, pulses, exp_pulses);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk({gclk_o, data_o, frame_pulse_o, ref8k_o} === 4'b0, "R11 outputs in reset",
        int'({gclk_o, data_o, frame_pulse_o, ref8k_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11: first enabled bit after reset is the overhead position, no strobe
    run_frame(1'b1, 24'h00F00F, 24'h00F00F, 1'b0, "R11 start-up alignment");

    // R3 R5 R6: table of modes and masks
    foreach (VEC[i]) begin
      run_frame(VEC[i][24], VEC[i][23:0], VEC[i][23:0], 1'b1,
                VEC[i][24] ? "R3 R5 gapped vector" : "R6 full-rate vector");
    end

    // R1: wrap after 192 with no strobe
    run_frame(1'b1, 24'h0F0F0F, 24'h0F0F0F, 1'b0, "R1 free-running wrap");

    // R4: mid-frame mask change ignored, applied next frame
    run_frame(1'b1, 24'h0000F0, 24'hFFFFFF, 1'b1, "R4 late mask ignored");
    run_frame(1'b1, 24'hFFFFFF, 24'hFFFFFF, 1'b0, "R4 mask taken next frame");

    // R8: re-phase mid-frame
    for (int k = 0; k < 70; k++) bit_step(1'b0, 1'b1, 24'h333333, 1'b1);
    run_frame(1'b1, 24'h333333, 24'h333333, 1'b1, "R8 resync mid-frame");
    for (int k = 0; k < 5; k++) bit_step(1'b0, 1'b0, 24'h0, 1'b1);
    run_frame(1'b0, 24'h0, 24'h0, 1'b1, "R8 resync full-rate");

    // R10: no enable, no outputs
    bit_en_i = 1'b0; sync_i = 1'b0; data_i = 1'b1; gap_en_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({gclk_o, data_o, frame_pulse_o, ref8k_o} === 4'b0, "R10 idle cycle outputs",
        int'({gclk_o, data_o, frame_pulse_o, ref8k_o}), 0);

    // R9: reference pulse period, independent of strobes
    chk(ref_err == 0, "R9 reference pulse timing", ref_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule